// File: doc/BRIEF.md
# Privileged System Control Register File

This block holds sixteen 32-bit system control registers behind one write port and one combinational read port. Both ports share a single register index. Every write passes through a mask chosen by that index, so bits that have no meaning in a register are never stored and always read back as zero. Some registers are fully reserved and keep the value zero. The instruction-address register cannot hold an odd address.

A user-state input comes from the interrupt control logic and gates writes. In supervisor state every register can be written, subject to its mask. In user state only the multiplier-quotient register and the condition-status register accept data. A write to any other index leaves that register unchanged. It also raises a one-cycle privilege-violation strobe, which the exception logic turns into a privileged-operation program check.

Top module: `sysreg_file`

## Requirements
- R1: Indices 0 to 5 and index 9 are reserved: a write to them stores zero, and they always read as zero.
- R2: Index 6 (counter source), index 7 (counter) and index 10 (multiplier-quotient) store all 32 bits of the written data.
- R3: Index 13 (instruction address) stores the written data ANDed with 0xFFFFFFFE, so bit 0 always reads 0.
- R4: Index 11 (machine/program check status) keeps only the bits in 0x0000BE00 and 0x000000FE, which together form the mask 0x0000BEFE.
- R5: Indices 8, 12, 14 and 15 store the data ANDed with a parameter mask. The defaults are 0x0000000F for index 8, 0x0000FFFE for index 12, 0x00001FF7 for index 14 and 0x0000007F for index 15.
- R6: While `user_state` is 1, a write to index 10 or 15 is stored. A write to any other index stores nothing, and `priv_viol` is 1 in that same cycle.
- R7: While `user_state` is 0, a write to any index is stored through its mask, and `priv_viol` stays 0.
- R8: `rd_data` shows the stored value at `reg_idx` in the same cycle, with no clock delay. A write becomes visible after the clock edge that takes it.
- R9: Reset (`rst_n` low) clears all sixteen registers to zero.
- R10: `priv_viol` is 1 only in a cycle where `wr_en` is 1. It lasts one cycle for each rejected write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write request for the register at `reg_idx` |
| reg_idx | input | 4 | Register index, shared by read and write |
| wr_data | input | 32 | Data to write, before masking |
| user_state | input | 1 | 1 in user state, 0 in supervisor state |
| rd_data | output | 32 | Stored value of the register at `reg_idx` |
| priv_viol | output | 1 | Pulse marking a rejected user-state write |

## Verification
A rejected write and the read of the same register can fall in the same cycle. In that cycle `priv_viol` must rise while `rd_data` still shows the old value. The old value must also survive the clock edge. The bench provokes this by turning on user state and writing random data to privileged indices, in both directed and random cycles. A bench model holds the expected value of each register. In every cycle the bench compares the read value before the edge with that model, and compares the strobe with the privilege rule computed in the bench. Writes in supervisor state to the same indices come right after, to show that the state bit alone decides the outcome.

// File: rtl/sysreg_pkg.sv
package sysreg_pkg;
  localparam int unsigned NREGS  = 16;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned IDX_W  = $clog2(NREGS);

  typedef logic [DATA_W-1:0] word_t;
  typedef logic [IDX_W-1:0]  idx_t;

  // indices whose behaviour is tied to a fixed position
  localparam idx_t IX_CNT_SRC = idx_t'(6);
  localparam idx_t IX_CNT     = idx_t'(7);
  localparam idx_t IX_TSTAT   = idx_t'(8);
  localparam idx_t IX_RSV9    = idx_t'(9);
  localparam idx_t IX_MQ      = idx_t'(10);
  localparam idx_t IX_CHKSTAT = idx_t'(11);
  localparam idx_t IX_REQBUF  = idx_t'(12);
  localparam idx_t IX_IADDR   = idx_t'(13);
  localparam idx_t IX_ICTL    = idx_t'(14);
  localparam idx_t IX_CSTAT   = idx_t'(15);

  localparam word_t MACH_CAUSE_BITS = 32'h0000_BE00;
  localparam word_t PROG_CAUSE_BITS = 32'h0000_00FE;
  localparam word_t IADDR_KEEP      = 32'hFFFF_FFFE;

  // mask of storable bits for one index
  function automatic word_t keep_mask(input idx_t ix, input word_t ts_m,
                                      input word_t rb_m, input word_t ic_m,
                                      input word_t cs_m);
    word_t m;
    case (ix)
      IX_CNT_SRC, IX_CNT, IX_MQ: m = '1;
      IX_TSTAT:   m = ts_m;
      IX_CHKSTAT: m = MACH_CAUSE_BITS | PROG_CAUSE_BITS;
      IX_REQBUF:  m = rb_m;
      IX_IADDR:   m = IADDR_KEEP;
      IX_ICTL:    m = ic_m;
      IX_CSTAT:   m = cs_m;
      default:    m = '0; // 0..5 and 9
    endcase
    return m;
  endfunction

  // registers open to user-state writes
  function automatic logic user_writable(input idx_t ix);
    return (ix == IX_MQ) || (ix == IX_CSTAT);
  endfunction
endpackage

// File: rtl/sysreg_mask_sel.sv
module sysreg_mask_sel
  import sysreg_pkg::*;
#(
  parameter word_t TS_MASK  = 32'h0000_000F,
  parameter word_t IRB_MASK = 32'h0000_FFFE,
  parameter word_t ICS_MASK = 32'h0000_1FF7,
  parameter word_t CS_MASK  = 32'h0000_007F
) (
  input  idx_t  idx,
  input  word_t raw,
  output word_t masked
);
  word_t mask_w;
  always_comb mask_w = keep_mask(idx, TS_MASK, IRB_MASK, ICS_MASK, CS_MASK);
  assign masked = raw & mask_w;
endmodule

// File: rtl/sysreg_priv_gate.sv
module sysreg_priv_gate
  import sysreg_pkg::*;
(
  input  logic we,
  input  logic user,
  input  idx_t idx,
  output logic commit,
  output logic viol
);
  logic allowed;
  always_comb begin
    allowed = !user || user_writable(idx);
    commit  = we && allowed;
    viol    = we && !allowed;
  end
endmodule

// File: rtl/sysreg_store.sv
module sysreg_store
  import sysreg_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  commit,
  input  idx_t  idx,
  input  word_t wval,
  output word_t rval
);
  word_t regs [NREGS];

  for (genvar g = 0; g < NREGS; g++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        regs[g] <= '0;
      else if (commit && (idx == idx_t'(g)))
        regs[g] <= wval;
    end
  end

  assign rval = regs[idx];
endmodule

// File: rtl/sysreg_file.sv
module sysreg_file
  import sysreg_pkg::*;
#(
  parameter logic [31:0] TS_MASK  = 32'h0000_000F,
  parameter logic [31:0] IRB_MASK = 32'h0000_FFFE,
  parameter logic [31:0] ICS_MASK = 32'h0000_1FF7,
  parameter logic [31:0] CS_MASK  = 32'h0000_007F
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [3:0]  reg_idx,
  input  logic [31:0] wr_data,
  input  logic        user_state,
  output logic [31:0] rd_data,
  output logic        priv_viol
);
  // named internal events for the checker
  logic  commit_w;
  logic  viol_w;
  word_t masked_w;

  sysreg_mask_sel #(
    .TS_MASK(TS_MASK), .IRB_MASK(IRB_MASK),
    .ICS_MASK(ICS_MASK), .CS_MASK(CS_MASK)
  ) u_mask (
    .idx(reg_idx), .raw(wr_data), .masked(masked_w)
  );

  sysreg_priv_gate u_gate (
    .we(wr_en), .user(user_state), .idx(reg_idx),
    .commit(commit_w), .viol(viol_w)
  );

  sysreg_store u_store (
    .clk(clk), .rst_n(rst_n), .commit(commit_w), .idx(reg_idx),
    .wval(masked_w), .rval(rd_data)
  );

  assign priv_viol = viol_w;
endmodule

// File: rtl/sysreg_file_chk.sv
module sysreg_file_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic [3:0]  reg_idx,
  input logic [31:0] wr_data,
  input logic        user_state,
  input logic [31:0] rd_data,
  input logic        priv_viol,
  input logic        commit_w
);
  p_reserved_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_idx <= 4'd5 || reg_idx == 4'd9) |-> rd_data == 32'h0);

  p_mq_full_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && reg_idx == 4'd10) |=> (reg_idx != 4'd10 || rd_data == $past(wr_data)));

  p_iaddr_even_r3: assert property (@(posedge clk) disable iff (!rst_n)
    reg_idx == 4'd13 |-> rd_data[0] == 1'b0);

  p_chk_mask_r4: assert property (@(posedge clk) disable iff (!rst_n)
    reg_idx == 4'd11 |-> (rd_data & ~32'h0000_BEFE) == 32'h0);

  p_user_reject_r6: assert property (@(posedge clk) disable iff (!rst_n)
    priv_viol |=> (reg_idx != $past(reg_idx) || rd_data == $past(rd_data)));

  p_user_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
    priv_viol |-> (user_state && reg_idx != 4'd10 && reg_idx != 4'd15));

  p_super_no_viol_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !user_state |-> !priv_viol);

  p_viol_with_we_r10: assert property (@(posedge clk) disable iff (!rst_n)
    priv_viol |-> (wr_en && !commit_w));
endmodule

bind sysreg_file sysreg_file_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .reg_idx(reg_idx),
  .wr_data(wr_data), .user_state(user_state), .rd_data(rd_data),
  .priv_viol(priv_viol), .commit_w(commit_w)
);

// File: tb/sysreg_file_tb.sv
module sysreg_file_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  reg_idx = '0;
  logic [31:0] wr_data = '0;
  logic        user_state = 1'b0;
  logic [31:0] rd_data;
  logic        priv_viol;

  int checks = 0;
  int fails  = 0;
  logic [31:0] model [16];

  always #10 clk = ~clk; // 50 MHz

  sysreg_file u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .reg_idx(reg_idx),
    .wr_data(wr_data), .user_state(user_state),
    .rd_data(rd_data), .priv_viol(priv_viol)
  );

  // storable bits, written from the requirement list
  function automatic logic [31:0] exp_mask(input int i);
    if (i == 6 || i == 7 || i == 10) return 32'hFFFF_FFFF;   // R2
    if (i == 13) return 32'hFFFF_FFFE;                       // R3
    if (i == 11) return 32'h0000_BEFE;                       // R4
    if (i == 8)  return 32'h0000_000F;                       // R5
    if (i == 12) return 32'h0000_FFFE;                       // R5
    if (i == 14) return 32'h0000_1FF7;                       // R5
    if (i == 15) return 32'h0000_007F;                       // R5
    return 32'h0;                                            // R1
  endfunction

  function automatic logic exp_reject(input logic u, input int i);
    return u && !(i == 10 || i == 15);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // drive one cycle at negedge, check mid-low, then pass the rising edge
  task automatic cycle(input logic we, input int i, input logic [31:0] d, input logic u);
    @(negedge clk);
    wr_en = we; reg_idx = 4'(i); wr_data = d; user_state = u;
    #2;
    check("R8 read before edge", rd_data, model[i]);
    check(we ? (u ? "R6 strobe" : "R7 strobe") : "R10 strobe",
          {31'b0, priv_viol}, {31'b0, we && exp_reject(u, i)});
    @(posedge clk);
    if (we && !exp_reject(u, i)) model[i] = d & exp_mask(i);
  endtask

  logic done = 1'b0;
  initial begin
    #(20 * 200000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    for (int k = 0; k < 16; k++) model[k] = '0;
    repeat (3) @(posedge clk);
    #2;
    for (int k = 0; k < 16; k++) begin
      reg_idx = 4'(k); #1;
      check("R9 reset value", rd_data, 32'h0);
    end
    @(negedge clk); rst_n = 1'b1;

    // directed: supervisor writes of all ones to every index (R1..R5, R7)
    for (int k = 0; k < 16; k++) cycle(1'b1, k, 32'hFFFF_FFFF, 1'b0);
    for (int k = 0; k < 16; k++) cycle(1'b0, k, 32'h0, 1'b0);
    // R3: odd instruction address
    cycle(1'b1, 13, 32'h0000_1235, 1'b0);
    cycle(1'b0, 13, 32'h0, 1'b0);
    check("R3 even address", rd_data, 32'h0000_1234);
    // R6: user write to privileged index and read of same index coincide
    cycle(1'b1, 13, 32'h0000_0000, 1'b1);
    cycle(1'b0, 13, 32'h0, 1'b1);
    check("R6 rejected write kept", rd_data, 32'h0000_1234);
    cycle(1'b1, 10, 32'hDEAD_BEEF, 1'b1);
    cycle(1'b1, 15, 32'hFFFF_FFFF, 1'b1);
    cycle(1'b0, 10, 32'h0, 1'b1);
    check("R2 user mq write", rd_data, 32'hDEAD_BEEF);
    cycle(1'b1, 11, 32'hFFFF_FFFF, 1'b1);
    cycle(1'b1, 11, 32'h0000_0001, 1'b0);
    cycle(1'b0, 11, 32'h0, 1'b0);
    check("R4 low bit dropped", rd_data, 32'h0);

    // constrained random
    for (int n = 0; n < 600; n++) begin
      int i;
      logic we, u;
      i  = int'($urandom_range(0, 15));
      we = ($urandom_range(0, 3) != 0);
      u  = ($urandom_range(0, 1) == 1);
      cycle(we, i, $urandom(), u);
    end
    for (int k = 0; k < 16; k++) cycle(1'b0, k, 32'h0, 1'b0);

    // R9: reset in the middle of operation
    @(negedge clk); rst_n = 1'b0; #2;
    for (int k = 0; k < 16; k++) model[k] = '0;
    for (int k = 0; k < 16; k++) begin
      reg_idx = 4'(k); #1;
      check("R9 mid-run reset", rd_data, 32'h0);
    end
    @(negedge clk); rst_n = 1'b1;
    cycle(1'b1, 9, 32'hFFFF_FFFF, 1'b0);
    cycle(1'b0, 9, 32'h0, 1'b0);
    check("R1 reserved 9", rd_data, 32'h0);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule